// File: doc/BRIEF.md
# Low-Power Mode Wake Sequencer

This block moves a small controller between three power modes: active, suspend and standby. A low-power mode can be requested in two ways. Local software writes a mode request, or an external host writes the same request through a mailbox path. When both arrive in the same cycle, the software request takes priority. The block then waits until the outstanding-transaction flag drops. After that it drives the clock-gate, oscillator-enable, PLL-enable, transceiver-enable, core-power and core-reset controls for the requested mode. It also tells the pads to hold their state.

Every asynchronous wake input first passes through a multi-stage synchronizer. Each mode has its own set of wake sources. Suspend listens to all eight sources. Standby listens to four: bus-power detection, the flow-control level, interface control line 0 and the reset pin. When an enabled source fires, the block does the following:
- It records a one-hot cause code.
- It turns the oscillator, PLL, transceiver and core power back on.
- It holds the clocks gated for a parameterised lock window.
- It returns to active.

The core reset is held through that window only when the core has to restart from the beginning, that is after standby or after a wake from the reset pin. Otherwise the core resumes where it stopped.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the outputs show active mode: clk_run, pll_en, osc_en, xcvr_en and core_pwr_en are 1, core_rst and io_hold are 0, lp_mode is 0 and wake_cause is 0.
- R2: In active mode, a request with mode code 1 (suspend) or 2 (standby) on either request port starts entry. When both ports are valid in the same cycle, the software port wins. Codes 0 and 3 are ignored.
- R3: After a request is accepted, the block stays in active-mode outputs for as long as xact_pending is 1. It enters the low-power mode on the first clock edge at which xact_pending is 0.
- R4: In suspend, the outputs are: lp_mode = 1, clk_run = 0, pll_en = 0, io_hold = 1, core_rst = 0, and osc_en, xcvr_en and core_pwr_en stay 1.
- R5: In standby, the outputs are: lp_mode = 2, clk_run, pll_en, osc_en, xcvr_en and core_pwr_en are 0, and core_rst and io_hold are 1.
- R6: In suspend, all eight sources can wake the block. D+, D- and the OTG ID input wake on any difference from the value each had at mode entry, and a steady level does not wake them. The SuperSpeed resume, bus power and control line 0 inputs wake when high. The reset pin wakes when low.
- R7: In standby, only the bus power, flow-control, control line 0 and reset pin sources can wake the block. Activity on D+, D-, the OTG ID input and the SuperSpeed resume input leaves standby unchanged.
- R8: The flow-control (CTS) wake is a level detect. It is active high when cts_pol is 1 and active low when cts_pol is 0.
- R9: After a wake, pll_en, osc_en, xcvr_en and core_pwr_en are 1 and clk_run is 0 for exactly LOCK_CYCLES cycles. After that window the block is active again.
- R10: During the lock window, core_rst is 1 if the block woke from standby or the cause was the reset pin, and 0 otherwise. core_rst is 0 in active mode.
- R11: wake_cause takes a one-hot code at each wake and holds it until the next wake. The bit positions are: reset pin 0, bus power 1, CTS 2, control line 0 3, D+ 4, D- 5, OTG ID 6, SuperSpeed resume 7. When several sources fire together, the lowest bit wins.
- R12: A mode request is ignored while the block is in suspend, in standby or in the lock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_req_valid | input | 1 | Local software mode-request strobe |
| sw_req_mode | input | 2 | Mode code requested by software |
| host_req_valid | input | 1 | External host mailbox request strobe |
| host_req_mode | input | 2 | Mode code requested by the host |
| xact_pending | input | 1 | High while transactions are still outstanding |
| cts_pol | input | 1 | Active level of the CTS wake |
| dp_in | input | 1 | D+ line (edge wake) |
| dm_in | input | 1 | D- line (edge wake) |
| otg_id_in | input | 1 | OTG ID input (edge wake) |
| ss_resume_in | input | 1 | SuperSpeed receive resume indication |
| vbus_in | input | 1 | Bus power detect |
| cts_in | input | 1 | UART CTS level |
| ctl0_in | input | 1 | Interface control line 0 |
| ext_rst_n_in | input | 1 | Active-low reset pin |
| clk_run | output | 1 | Clock enable toward the core clock gate |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Crystal oscillator enable |
| xcvr_en | output | 1 | USB transceiver enable |
| core_pwr_en | output | 1 | Core power-domain enable |
| core_rst | output | 1 | Core reset (restart from program start) |
| io_hold | output | 1 | Pad state hold |
| lp_mode | output | 2 | Present mode: 0 active, 1 suspend, 2 standby |
| wake_cause | output | 8 | One-hot source of the most recent wake |

## Verification
The hardest case to reach from the ports is an edge-type wake whose line already sat at a non-idle level when the mode was entered. In that case only a change relative to the captured baseline may wake the block. The stimulus leaves D+ low after one wake, enters suspend again with D+ still low, holds it there, and then raises it. Further directed cases cover the following:
- sources that fire together;
- lines toggled in standby that must be ignored;
- requests issued inside the lock window.

Random rounds also drive pairs of sources under random modes and polarity.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

   typedef enum logic [1:0] {
      MODE_ACTIVE  = 2'd0,
      MODE_SUSPEND = 2'd1,
      MODE_STANDBY = 2'd2
   } lp_mode_e;

   typedef enum logic [2:0] {
      ST_ACT,
      ST_DRAIN,
      ST_SUSP,
      ST_STBY,
      ST_LOCK
   } seq_st_e;

   localparam int NSRC   = 8;
   localparam int W_RST  = 0;
   localparam int W_VBUS = 1;
   localparam int W_CTS  = 2;
   localparam int W_CTL0 = 3;
   localparam int W_DP   = 4;
   localparam int W_DM   = 5;
   localparam int W_OTG  = 6;
   localparam int W_SSRX = 7;

   // sources compared against a baseline captured at mode entry
   localparam logic [NSRC-1:0] EDGE_SRC = 8'b0111_0000;
   // sources honoured in each low-power mode
   localparam logic [NSRC-1:0] SUSP_SET = 8'b1111_1111;
   localparam logic [NSRC-1:0] STBY_SET = 8'b0000_1111;
   // idle level of each synchronized input after power-on reset
   localparam logic [NSRC-1:0] IDLE_VAL = 8'b0101_0001;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int              WIDTH   = 8,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
   import pwr_wake_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] sync_in,
   input  logic            snap,
   input  logic            cts_pol,
   input  logic [NSRC-1:0] allow,
   output logic [NSRC-1:0] hit_onehot,
   output logic            hit_any
);

   logic [NSRC-1:0] raw;
   logic [NSRC-1:0] masked;
   logic [NSRC-1:0] neg;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (EDGE_SRC[i]) begin : g_edge
         logic base_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    base_q <= IDLE_VAL[i];
            else if (snap) base_q <= sync_in[i];
         end
         assign raw[i] = sync_in[i] ^ base_q;
      end else if (i == W_RST) begin : g_low
         assign raw[i] = ~sync_in[i];
      end else if (i == W_CTS) begin : g_pol
         assign raw[i] = (sync_in[i] == cts_pol);
      end else begin : g_high
         assign raw[i] = sync_in[i];
      end
   end

   assign masked     = raw & allow;
   assign neg        = ~masked + NSRC'(1);
   assign hit_onehot = masked & neg;
   assign hit_any    = |masked;

endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
   import pwr_wake_pkg::*;
#(
   parameter int LOCK_CYCLES = 16,
   localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_req_valid,
   input  logic [1:0]      sw_req_mode,
   input  logic            host_req_valid,
   input  logic [1:0]      host_req_mode,
   input  logic            xact_pending,
   input  logic [NSRC-1:0] hit_onehot,
   input  logic            hit_any,
   output logic            snap,
   output logic [NSRC-1:0] allow,
   output logic            clk_run,
   output logic            pll_en,
   output logic            osc_en,
   output logic            xcvr_en,
   output logic            core_pwr_en,
   output logic            core_rst,
   output logic            io_hold,
   output logic [1:0]      lp_mode,
   output logic [NSRC-1:0] wake_cause
);

   seq_st_e        st_q;
   lp_mode_e       tgt_q;
   logic [CNT_W-1:0] cnt_q;
   logic           rst_exit_q;
   logic           sw_ok, host_ok, req_any;
   lp_mode_e       req_mode;

   assign sw_ok   = sw_req_valid &&
                    (sw_req_mode == MODE_SUSPEND || sw_req_mode == MODE_STANDBY);
   assign host_ok = host_req_valid &&
                    (host_req_mode == MODE_SUSPEND || host_req_mode == MODE_STANDBY);
   assign req_any  = sw_ok || host_ok;
   assign req_mode = sw_ok ? lp_mode_e'(sw_req_mode) : lp_mode_e'(host_req_mode);

   assign snap = (st_q == ST_DRAIN) && !xact_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_ACT;
         tgt_q      <= MODE_ACTIVE;
         cnt_q      <= '0;
         rst_exit_q <= 1'b0;
         wake_cause <= '0;
      end else begin
         case (st_q)
            ST_ACT: begin
               if (req_any) begin
                  tgt_q <= req_mode;
                  st_q  <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (!xact_pending)
                  st_q <= (tgt_q == MODE_STANDBY) ? ST_STBY : ST_SUSP;
            end
            ST_SUSP, ST_STBY: begin
               if (hit_any) begin
                  wake_cause <= hit_onehot;
                  rst_exit_q <= (st_q == ST_STBY) || hit_onehot[W_RST];
                  cnt_q      <= '0;
                  st_q       <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               if (cnt_q == CNT_W'(LOCK_CYCLES - 1)) st_q  <= ST_ACT;
               else                                  cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= ST_ACT;
         endcase
      end
   end

   always_comb begin
      allow       = '0;
      clk_run     = 1'b0;
      pll_en      = 1'b1;
      osc_en      = 1'b1;
      xcvr_en     = 1'b1;
      core_pwr_en = 1'b1;
      core_rst    = 1'b0;
      io_hold     = 1'b0;
      lp_mode     = MODE_ACTIVE;
      case (st_q)
         ST_ACT, ST_DRAIN: clk_run = 1'b1;
         ST_SUSP: begin
            allow   = SUSP_SET;
            pll_en  = 1'b0;
            io_hold = 1'b1;
            lp_mode = MODE_SUSPEND;
         end
         ST_STBY: begin
            allow       = STBY_SET;
            pll_en      = 1'b0;
            osc_en      = 1'b0;
            xcvr_en     = 1'b0;
            core_pwr_en = 1'b0;
            core_rst    = 1'b1;
            io_hold     = 1'b1;
            lp_mode     = MODE_STANDBY;
         end
         ST_LOCK: core_rst = rst_exit_q;
         default: clk_run = 1'b0;
      endcase
   end

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwr_wake_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_req_valid,
   input  logic [1:0] sw_req_mode,
   input  logic       host_req_valid,
   input  logic [1:0] host_req_mode,
   input  logic       xact_pending,
   input  logic       cts_pol,
   input  logic       dp_in,
   input  logic       dm_in,
   input  logic       otg_id_in,
   input  logic       ss_resume_in,
   input  logic       vbus_in,
   input  logic       cts_in,
   input  logic       ctl0_in,
   input  logic       ext_rst_n_in,
   output logic       clk_run,
   output logic       pll_en,
   output logic       osc_en,
   output logic       xcvr_en,
   output logic       core_pwr_en,
   output logic       core_rst,
   output logic       io_hold,
   output logic [1:0] lp_mode,
   output logic [7:0] wake_cause
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("pwr_wake_ctrl: SYNC_STAGES must be at least 2");
   end
   if (LOCK_CYCLES < 1) begin : g_chk_lock
      $error("pwr_wake_ctrl: LOCK_CYCLES must be at least 1");
   end
   if (NSRC != 8) begin : g_chk_src
      $error("pwr_wake_ctrl: wake_cause port expects eight sources");
   end

   logic [NSRC-1:0] wake_raw;
   logic [NSRC-1:0] wake_sync;
   logic [NSRC-1:0] allow;
   logic [NSRC-1:0] hit_onehot;
   logic            hit_any;
   logic            snap;

   assign wake_raw = {ss_resume_in, otg_id_in, dm_in, dp_in,
                      ctl0_in, cts_in, vbus_in, ext_rst_n_in};

   pwr_wake_sync #(
      .WIDTH  (NSRC),
      .STAGES (SYNC_STAGES),
      .RST_VAL(IDLE_VAL)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (wake_raw),
      .q    (wake_sync)
   );

   pwr_wake_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (wake_sync),
      .snap      (snap),
      .cts_pol   (cts_pol),
      .allow     (allow),
      .hit_onehot(hit_onehot),
      .hit_any   (hit_any)
   );

   pwr_wake_seq #(
      .LOCK_CYCLES(LOCK_CYCLES)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .sw_req_valid  (sw_req_valid),
      .sw_req_mode   (sw_req_mode),
      .host_req_valid(host_req_valid),
      .host_req_mode (host_req_mode),
      .xact_pending  (xact_pending),
      .hit_onehot    (hit_onehot),
      .hit_any       (hit_any),
      .snap          (snap),
      .allow         (allow),
      .clk_run       (clk_run),
      .pll_en        (pll_en),
      .osc_en        (osc_en),
      .xcvr_en       (xcvr_en),
      .core_pwr_en   (core_pwr_en),
      .core_rst      (core_rst),
      .io_hold       (io_hold),
      .lp_mode       (lp_mode),
      .wake_cause    (wake_cause)
   );

endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       xact_pending,
   input logic       clk_run,
   input logic       pll_en,
   input logic       osc_en,
   input logic       xcvr_en,
   input logic       core_pwr_en,
   input logic       core_rst,
   input logic       io_hold,
   input logic [1:0] lp_mode,
   input logic [7:0] wake_cause
);

   assert_drain_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'd0 && clk_run && xact_pending) |=> (lp_mode == 2'd0));

   assert_susp_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'd1) |-> (!clk_run && !pll_en && io_hold && !core_rst
                             && osc_en && core_pwr_en));

   assert_stby_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == 2'd2) |-> (!clk_run && !osc_en && !xcvr_en && !core_pwr_en
                             && core_rst && io_hold));

   assert_exit_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode != 2'd0) |=> (lp_mode == $past(lp_mode) || (pll_en && !clk_run)));

   assert_active_no_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clk_run |-> !core_rst);

   assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wake_cause));

   assert_cause_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clk_run |=> $stable(wake_cause));

endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xact_pending(xact_pending),
   .clk_run     (clk_run),
   .pll_en      (pll_en),
   .osc_en      (osc_en),
   .xcvr_en     (xcvr_en),
   .core_pwr_en (core_pwr_en),
   .core_rst    (core_rst),
   .io_hold     (io_hold),
   .lp_mode     (lp_mode),
   .wake_cause  (wake_cause)
);

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;

   localparam int LC = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_req_valid = 1'b0, host_req_valid = 1'b0;
   logic [1:0] sw_req_mode = 2'd0, host_req_mode = 2'd0;
   logic xact_pending = 1'b0, cts_pol = 1'b1;
   logic dp_in = 1'b1, dm_in = 1'b0, otg_id_in = 1'b1, ss_resume_in = 1'b0;
   logic vbus_in = 1'b0, cts_in = 1'b0, ctl0_in = 1'b0, ext_rst_n_in = 1'b1;
   logic clk_run, pll_en, osc_en, xcvr_en, core_pwr_en, core_rst, io_hold;
   logic [1:0] lp_mode;
   logic [7:0] wake_cause;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   pwr_wake_ctrl #(.SYNC_STAGES(2), .LOCK_CYCLES(LC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .sw_req_valid(sw_req_valid), .sw_req_mode(sw_req_mode),
      .host_req_valid(host_req_valid), .host_req_mode(host_req_mode),
      .xact_pending(xact_pending), .cts_pol(cts_pol),
      .dp_in(dp_in), .dm_in(dm_in), .otg_id_in(otg_id_in),
      .ss_resume_in(ss_resume_in), .vbus_in(vbus_in), .cts_in(cts_in),
      .ctl0_in(ctl0_in), .ext_rst_n_in(ext_rst_n_in),
      .clk_run(clk_run), .pll_en(pll_en), .osc_en(osc_en), .xcvr_en(xcvr_en),
      .core_pwr_en(core_pwr_en), .core_rst(core_rst), .io_hold(io_hold),
      .lp_mode(lp_mode), .wake_cause(wake_cause)
   );

   // packed view: {clk_run,pll,osc,xcvr,pwr,core_rst,io_hold,lp_mode}
   function automatic logic [8:0] exp_bus(input logic [1:0] m);
      case (m)
         2'd1:    return {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1};
         2'd2:    return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2};
         default: return {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0};
      endcase
   endfunction

   function automatic logic [7:0] allowed(input logic [1:0] m);
      return (m == 2'd2) ? 8'h0F : 8'hFF;
   endfunction

   function automatic logic [7:0] exp_cause(input logic [1:0] m, input logic [7:0] drv);
      logic [7:0] a;
      a = drv & allowed(m);
      return a & (~a + 8'd1);
   endfunction

   function automatic logic exp_rst(input logic [1:0] m, input logic [7:0] c);
      return (m == 2'd2) || c[0];
   endfunction

   function automatic logic [8:0] obs_bus();
      return {clk_run, pll_en, osc_en, xcvr_en, core_pwr_en, core_rst, io_hold, lp_mode};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_idle();
      dp_in = 1'b1; dm_in = 1'b0; otg_id_in = 1'b1; ss_resume_in = 1'b0;
      vbus_in = 1'b0; cts_in = ~cts_pol; ctl0_in = 1'b0; ext_rst_n_in = 1'b1;
   endtask

   task automatic apply_mask(input logic [7:0] m);
      if (m[0]) ext_rst_n_in = 1'b0;
      if (m[1]) vbus_in = 1'b1;
      if (m[2]) cts_in = cts_pol;
      if (m[3]) ctl0_in = 1'b1;
      if (m[4]) dp_in = ~dp_in;
      if (m[5]) dm_in = ~dm_in;
      if (m[6]) otg_id_in = ~otg_id_in;
      if (m[7]) ss_resume_in = 1'b1;
   endtask

   task automatic sw_req(input logic [1:0] m);
      @(negedge clk); sw_req_valid = 1'b1; sw_req_mode = m;
      @(negedge clk); sw_req_valid = 1'b0;
   endtask

   task automatic enter(input logic [1:0] m, input string tag);
      sw_req(m);
      @(negedge clk);
      chk(tag, {23'd0, obs_bus()}, {23'd0, exp_bus(m)});
   endtask

   // drive sources, then check cause, reset policy and exact lock window
   task automatic wake(input logic [1:0] m, input logic [7:0] drv, input string tag);
      logic [7:0] c;
      c = exp_cause(m, drv);
      @(negedge clk); apply_mask(drv);
      repeat (3) @(negedge clk);
      chk({tag, " cause R11"}, {24'd0, wake_cause}, {24'd0, c});
      chk({tag, " core_rst R10"}, {31'd0, core_rst}, {31'd0, exp_rst(m, c)});
      chk({tag, " lock start R9"}, {27'd0, clk_run, pll_en, osc_en, xcvr_en, core_pwr_en},
          {27'd0, 5'b01111});
      repeat (LC - 1) @(negedge clk);
      chk({tag, " lock end R9"}, {30'd0, clk_run, pll_en}, {30'd0, 2'b01});
      @(negedge clk);
      chk({tag, " active R9"}, {23'd0, obs_bus()}, {23'd0, exp_bus(2'd0)});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      set_idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset R1", {15'd0, wake_cause, obs_bus()}, {15'd0, 8'h00, exp_bus(2'd0)});

      // R2: invalid codes ignored on both ports
      sw_req(2'd3); repeat (3) @(negedge clk);
      chk("code3 ignored R2", {30'd0, lp_mode}, 32'd0);
      @(negedge clk); host_req_valid = 1'b1; host_req_mode = 2'd0;
      @(negedge clk); host_req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("code0 ignored R2", {31'd0, clk_run}, 32'd1);

      // R2: host path, and software priority
      @(negedge clk); host_req_valid = 1'b1; host_req_mode = 2'd2;
      @(negedge clk); host_req_valid = 1'b0;
      @(negedge clk);
      chk("host standby R2 R5", {23'd0, obs_bus()}, {23'd0, exp_bus(2'd2)});
      wake(2'd2, 8'h02, "stby vbus");
      set_idle(); repeat (3) @(negedge clk);
      @(negedge clk); sw_req_valid = 1'b1; sw_req_mode = 2'd1;
      host_req_valid = 1'b1; host_req_mode = 2'd2;
      @(negedge clk); sw_req_valid = 1'b0; host_req_valid = 1'b0;
      @(negedge clk);
      chk("sw wins R2 R4", {30'd0, lp_mode}, 32'd1);
      wake(2'd1, 8'h08, "susp ctl0");
      set_idle(); repeat (3) @(negedge clk);

      // R3: drain holds entry
      xact_pending = 1'b1;
      sw_req(2'd1); repeat (5) @(negedge clk);
      chk("drain hold R3", {23'd0, obs_bus()}, {23'd0, exp_bus(2'd0)});
      xact_pending = 1'b0;
      @(negedge clk);
      chk("drain release R3 R4", {23'd0, obs_bus()}, {23'd0, exp_bus(2'd1)});

      // R6: steady D+ level does not wake; a change does
      repeat (6) @(negedge clk);
      chk("dp level R6", {30'd0, lp_mode}, 32'd1);
      wake(2'd1, 8'h10, "dp fall R6");
      // dp is now low: re-enter with low baseline, rising edge must wake
      repeat (3) @(negedge clk);
      enter(2'd1, "reenter R4");
      repeat (6) @(negedge clk);
      chk("dp low baseline R6", {30'd0, lp_mode}, 32'd1);
      wake(2'd1, 8'h10, "dp rise R6");
      set_idle(); repeat (3) @(negedge clk);

      // R7: standby ignores edge sources and resume
      enter(2'd2, "stby R5");
      @(negedge clk); apply_mask(8'hF0);
      repeat (8) @(negedge clk);
      chk("stby ignores R7", {23'd0, obs_bus()}, {23'd0, exp_bus(2'd2)});
      set_idle(); repeat (3) @(negedge clk);
      chk("stby still R7", {30'd0, lp_mode}, 32'd2);
      wake(2'd2, 8'h01, "stby rstpin R10");
      set_idle(); repeat (3) @(negedge clk);

      // R8: CTS polarity low
      cts_pol = 1'b0; set_idle(); repeat (3) @(negedge clk);
      enter(2'd1, "cts susp R4");
      repeat (6) @(negedge clk);
      chk("cts inactive R8", {30'd0, lp_mode}, 32'd1);
      wake(2'd1, 8'h04, "cts low R8");
      cts_pol = 1'b1; set_idle(); repeat (3) @(negedge clk);

      // R10/R11: reset pin from suspend, simultaneous sources
      enter(2'd1, "rst susp");
      wake(2'd1, 8'h81, "susp rstpin R10");
      set_idle(); repeat (3) @(negedge clk);
      enter(2'd1, "prio susp");
      wake(2'd1, 8'h12, "prio vbus R11");
      set_idle(); repeat (6) @(negedge clk);
      chk("cause held R11", {24'd0, wake_cause}, 32'h02);

      // R12: requests inside suspend and lock are ignored
      enter(2'd1, "ign susp");
      sw_req(2'd2); repeat (3) @(negedge clk);
      chk("req in susp R12", {23'd0, obs_bus()}, {23'd0, exp_bus(2'd1)});
      @(negedge clk); vbus_in = 1'b1;
      repeat (4) @(negedge clk);
      sw_req(2'd1);
      set_idle();
      repeat (LC + 4) @(negedge clk);
      chk("req in lock R12", {23'd0, obs_bus()}, {23'd0, exp_bus(2'd0)});

      // random rounds
      for (int it = 0; it < 30; it++) begin
         logic [1:0] m;
         logic [7:0] drv;
         m = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
         cts_pol = 1'($urandom);
         set_idle(); repeat (3) @(negedge clk);
         drv = 8'd1 << ($urandom % 8);
         drv = drv | (8'd1 << ($urandom % 8));
         if ((drv & allowed(m)) == 8'd0) drv = drv | (8'd1 << ($urandom % 4));
         enter(m, "rand enter R4 R5");
         wake(m, drv, "rand R6 R7");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule